// File: doc/BRIEF.md
# Memory Region Access Timer

This block works out how many bus clocks a single memory access takes. It then counts those clocks down. A requester presents a 32-bit address, a width flag (32-bit word or narrower) and a sequential flag, together with the current wait configuration, and pulses a strobe. The block then does three things:

- It decodes which memory region the address falls in.
- It computes the access cost from the region, the bus width of that region and the sequential/non-sequential status.
- It latches the cost and the region, and holds `busy` high for exactly that many clocks. `ready` is raised in the last of those clocks.

The cartridge space spans 0x0800_0000 to 0x0FFF_FFFF. It is split into four windows of 32 MB, selected by address bits 26:25. Each window has its own timing fields. That space sits on a 16-bit bus, so a 32-bit access there costs a second, sequential transfer. Every 128 KB boundary restarts a burst.

Top module: `memwait_timer`

## Requirements
- R1: An address at or above 0x1000_0000, or below 0x0200_0000, costs 1 clock whatever the width.
- R2: Addresses 0x0200_0000–0x02FF_FFFF cost (16 − `cfg_eram_wait`) clocks for a narrow access and twice that for a 32-bit access.
- R3: Addresses 0x0300_0000–0x04FF_FFFF and 0x0700_0000–0x07FF_FFFF cost 1 clock. Addresses 0x0500_0000–0x06FF_FFFF cost 2 clocks for a 32-bit access and 1 clock otherwise.
- R4: In cartridge space, window w = address bits 26:25 has a non-sequential cost chosen by field `cfg_cart_nseq[2w+1:2w]`. Field values 0, 1, 2 and 3 give 5, 4, 3 and 9 clocks.
- R5: The sequential cost of windows 0, 1 and 2 is 2 when `cfg_cart_seqfast[w]` is 1. When that bit is 0, the cost is 3, 5 or 9 respectively. Window 3 has no such bit, and its sequential cost equals its non-sequential cost.
- R6: A cartridge access whose address bits 16:1 are all zero is charged as non-sequential even when `acc_seq` is 1.
- R7: A 32-bit cartridge access costs its first transfer plus one sequential cost of the same window.
- R8: `region_sel` is one-hot with bit 0 = below 0x0200_0000, bit 1 = 0x02 region, bit 2 = 0x03/0x04/0x07 regions, bit 3 = 0x05/0x06 regions, bit 4 = cartridge, bit 5 = unmapped.
- R9: A strobe accepted at a clock edge sets `cyc_count` = N and `region_sel` at that edge, and `busy` is then high for exactly N cycles. `ready` is high only in the N-th of them. A strobe present in that final cycle is accepted back-to-back.
- R10: The configuration inputs are sampled only when a strobe is accepted. A strobe while busy and not ready is ignored. While an access runs, `cyc_count` and `region_sel` hold.
- R11: After reset, `busy`, `ready`, `cyc_count` and `region_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_strobe | input | 1 | Start an access |
| acc_addr | input | 32 | Access address |
| acc_word | input | 1 | 1 = 32-bit access, 0 = narrower |
| acc_seq | input | 1 | 1 = sequential access |
| cfg_eram_wait | input | ERAM_W (4) | External-RAM wait field |
| cfg_cart_nseq | input | 8 | Two-bit non-sequential field per cartridge window |
| cfg_cart_seqfast | input | 3 | Fast-sequential bit for windows 0–2 |
| cyc_count | output | CNT_W (6) | Latched clock count of the current access |
| region_sel | output | 6 | Latched one-hot region |
| busy | output | 1 | Access in progress |
| ready | output | 1 | Final clock of the access |

## Verification
The bench builds the block with its defaults: a 4-bit external-RAM wait field and a derived 6-bit counter. This makes the longest access (32 clocks, wait field 0 with a 32-bit access) and the shortest (1 clock, wait field 15) both reachable. Every cartridge window is exercised with every field value that changes its cost, including the 128 KB restart with bit 0 set and the longest cartridge case of 18 clocks. Directed cases cover several situations: a configuration change during an access, a strobe ignored mid-access, and a back-to-back strobe in the ready cycle.

// File: rtl/memwait_pkg.sv
// Shared region indices and cartridge cost tables for the access timer.
package memwait_pkg;

    localparam int NREG = 6;   // number of decoded regions
    localparam int NWIN = 4;   // cartridge windows, picked by address bits 26:25
    localparam int CART_W = 5; // width of a cartridge cost (max 18)

    typedef enum int {
        RG_LOW   = 0,
        RG_ERAM  = 1,
        RG_FAST  = 2,
        RG_VIDEO = 3,
        RG_CART  = 4,
        RG_UNMAP = 5
    } region_e;

    // Non-sequential cartridge cost selected by a 2-bit field.
    function automatic logic [CART_W-1:0] nseq_cost(input logic [1:0] fld);
        case (fld)
            2'd0:    return CART_W'(5);
            2'd1:    return CART_W'(4);
            2'd2:    return CART_W'(3);
            default: return CART_W'(9);
        endcase
    endfunction

    // Slow sequential cartridge cost of a window whose fast bit is clear.
    function automatic logic [CART_W-1:0] seq_slow_cost(input int win);
        case (win)
            0:       return CART_W'(3);
            1:       return CART_W'(5);
            default: return CART_W'(9);
        endcase
    endfunction

endpackage

// File: rtl/memwait_decode.sv
// Region decoder: maps a 32-bit address onto a one-hot region vector.
// Assumes the region layout fixed by address bits 31:24.
module memwait_decode
    import memwait_pkg::*;
(
    input  logic [31:0]     addr,
    output logic [NREG-1:0] sel
);

    // Pick exactly one region from the top address byte.
    always_comb begin
        sel = '0;
        if (addr[31:28] != 4'h0) begin
            sel[RG_UNMAP] = 1'b1;
        end else begin
            case (addr[27:24])
                4'h0, 4'h1:       sel[RG_LOW]   = 1'b1;
                4'h2:             sel[RG_ERAM]  = 1'b1;
                4'h3, 4'h4, 4'h7: sel[RG_FAST]  = 1'b1;
                4'h5, 4'h6:       sel[RG_VIDEO] = 1'b1;
                default:          sel[RG_CART]  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/memwait_cart.sv
// Cartridge cost unit: per-window first-transfer and sequential costs,
// 128 KB burst restart and the extra half for a 32-bit access.
// Assumes the address is already known to be in cartridge space.
module memwait_cart
    import memwait_pkg::*;
(
    input  logic [31:0]       addr,
    input  logic              word,
    input  logic              seq,
    input  logic [2*NWIN-1:0] nseq_cfg,
    input  logic [NWIN-2:0]   seqfast_cfg,
    output logic [CART_W-1:0] cost
);

    logic [CART_W-1:0] n_cost [NWIN];
    logic [CART_W-1:0] s_cost [NWIN];

    // Per-window cost pair built from that window's own fields.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign n_cost[w] = nseq_cost(nseq_cfg[2*w +: 2]);
        if (w == NWIN - 1) begin : g_last
            assign s_cost[w] = n_cost[w];
        end else begin : g_fast
            assign s_cost[w] = seqfast_cfg[w] ? CART_W'(2) : seq_slow_cost(w);
        end
    end

    logic [1:0]        win;
    logic              restart;
    logic [CART_W-1:0] first;

    // First transfer cost, then the second half of a 32-bit access.
    always_comb begin
        win     = addr[26:25];
        restart = (addr[16:1] == 16'h0000);
        first   = (seq && !restart) ? s_cost[win] : n_cost[win];
        cost    = first + (word ? s_cost[win] : CART_W'(0));
    end

endmodule

// File: rtl/memwait_cnt.sv
// Countdown: loads a clock count and holds busy for that many cycles,
// raising ready in the last. Assumes a loaded count is never zero.
module memwait_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] total,
    output logic             busy,
    output logic             ready
);

    logic [CNT_W-1:0] rem;

    assign ready = busy && (rem == CNT_W'(1));

    // Load on accept, otherwise step down until the final clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            rem  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            rem  <= total;
        end else if (busy) begin
            if (rem == CNT_W'(1)) busy <= 1'b0;
            else                  rem  <= rem - CNT_W'(1);
        end
    end

    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ready |=> busy && (rem == $past(rem) - CNT_W'(1)));

    p_ready_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !load |=> !busy);

endmodule

// File: rtl/memwait_timer.sv
// Memory region access timer: decodes the region, computes the clock cost
// of one access from the sampled wait configuration, latches both on an
// accepted strobe and counts the access down. A strobe is accepted when
// idle or in the ready cycle; configuration is sampled only then.
module memwait_timer
    import memwait_pkg::*;
#(
    parameter int ERAM_W = 4,
    parameter int CNT_W  = $clog2((2 << ERAM_W) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_strobe,
    input  logic [31:0]       acc_addr,
    input  logic              acc_word,
    input  logic              acc_seq,
    input  logic [ERAM_W-1:0] cfg_eram_wait,
    input  logic [2*NWIN-1:0] cfg_cart_nseq,
    input  logic [NWIN-2:0]   cfg_cart_seqfast,
    output logic [CNT_W-1:0]  cyc_count,
    output logic [NREG-1:0]   region_sel,
    output logic              busy,
    output logic              ready
);

    logic [NREG-1:0]   dec_sel;
    logic [CART_W-1:0] cart_cost;
    logic [ERAM_W:0]   eram_base;
    logic [CNT_W-1:0]  total;
    logic              accept;

    memwait_decode u_dec (
        .addr (acc_addr),
        .sel  (dec_sel)
    );

    memwait_cart u_cart (
        .addr        (acc_addr),
        .word        (acc_word),
        .seq         (acc_seq),
        .nseq_cfg    (cfg_cart_nseq),
        .seqfast_cfg (cfg_cart_seqfast),
        .cost        (cart_cost)
    );

    // Cost of the presented access from its region.
    always_comb begin
        eram_base = (ERAM_W+1)'(1 << ERAM_W) - {1'b0, cfg_eram_wait};
        if (dec_sel[RG_ERAM])
            total = acc_word ? CNT_W'({eram_base, 1'b0}) : CNT_W'(eram_base);
        else if (dec_sel[RG_VIDEO])
            total = acc_word ? CNT_W'(2) : CNT_W'(1);
        else if (dec_sel[RG_CART])
            total = CNT_W'(cart_cost);
        else
            total = CNT_W'(1);
    end

    assign accept = acc_strobe && (!busy || ready);

    // Latch count and region of an accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_count  <= '0;
            region_sel <= '0;
        end else if (accept) begin
            cyc_count  <= total;
            region_sel <= dec_sel;
        end
    end

    memwait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .total (total),
        .busy  (busy),
        .ready (ready)
    );

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ready |=> $stable(cyc_count) && $stable(region_sel));

    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(region_sel));

    p_eram_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dec_sel[RG_ERAM] |=> (cyc_count != '0)
            && (cyc_count <= CNT_W'(2 << ERAM_W)));

    p_cart_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dec_sel[RG_CART] |=> (cyc_count >= CNT_W'(2))
            && (cyc_count <= CNT_W'(18)));

endmodule

// File: tb/sim_memwait_timer.sv
`timescale 1ns/1ps
module sim_memwait_timer;

    typedef struct packed {
        logic [31:0] a;
        logic        w;
        logic        s;
        logic [3:0]  e;
        logic [7:0]  n;
        logic [2:0]  q;
        logic [5:0]  c;
        logic [5:0]  r;
        logic [3:0]  rq;
    } vec_t;

    localparam logic [5:0] LOW = 6'b000001, ERM = 6'b000010, FST = 6'b000100,
                           VID = 6'b001000, CRT = 6'b010000, UNM = 6'b100000;
    localparam int NV = 31;

    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  LOW, 4'd1},  // R1
        '{32'h01FF_FFFC, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  LOW, 4'd1},  // R1
        '{32'h1000_0000, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  UNM, 4'd1},  // R1
        '{32'hFFFF_FFFC, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd1,  UNM, 4'd1},  // R1
        '{32'h0200_0010, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd13, ERM, 4'd2},  // R2
        '{32'h02FF_FFFC, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd26, ERM, 4'd2},  // R2
        '{32'h0200_0000, 1'b1, 1'b0, 4'd0, 8'hE4, 3'b010, 6'd32, ERM, 4'd2},  // R2
        '{32'h0200_0000, 1'b0, 1'b0, 4'd15,8'hE4, 3'b010, 6'd1,  ERM, 4'd2},  // R2
        '{32'h0300_0000, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  FST, 4'd3},  // R3
        '{32'h0400_0200, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  FST, 4'd3},  // R3
        '{32'h0700_0004, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  FST, 4'd3},  // R3
        '{32'h0500_0000, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd2,  VID, 4'd3},  // R3
        '{32'h0600_0002, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1,  VID, 4'd3},  // R3
        '{32'h0800_1000, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd5,  CRT, 4'd4},  // R4
        '{32'h0A00_1000, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd4,  CRT, 4'd4},  // R4
        '{32'h0C00_1000, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd3,  CRT, 4'd4},  // R4
        '{32'h0E00_1000, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd9,  CRT, 4'd4},  // R4
        '{32'h0900_1000, 1'b0, 1'b0, 4'd3, 8'h03, 3'b010, 6'd9,  CRT, 4'd4},  // R4
        '{32'h0FFF_FFFE, 1'b0, 1'b0, 4'd3, 8'h00, 3'b010, 6'd5,  CRT, 4'd4},  // R4
        '{32'h0800_1002, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd3,  CRT, 4'd5},  // R5
        '{32'h0A00_1002, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd2,  CRT, 4'd5},  // R5
        '{32'h0C00_1002, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd9,  CRT, 4'd5},  // R5
        '{32'h0E00_1002, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd9,  CRT, 4'd5},  // R5
        '{32'h0E00_1002, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b111, 6'd9,  CRT, 4'd5},  // R5
        '{32'h0800_1002, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b111, 6'd2,  CRT, 4'd5},  // R5
        '{32'h0802_0000, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd5,  CRT, 4'd6},  // R6
        '{32'h0A02_0001, 1'b0, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd4,  CRT, 4'd6},  // R6
        '{32'h0800_1000, 1'b1, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd8,  CRT, 4'd7},  // R7
        '{32'h0A00_1002, 1'b1, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd4,  CRT, 4'd7},  // R7
        '{32'h0C04_0000, 1'b1, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd12, CRT, 4'd7},  // R7 with R6
        '{32'h0E00_0000, 1'b1, 1'b1, 4'd3, 8'hE4, 3'b010, 6'd18, CRT, 4'd7}   // R7 with R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_strobe = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_word = 1'b0;
    logic        acc_seq = 1'b0;
    logic [3:0]  cfg_eram_wait = '0;
    logic [7:0]  cfg_cart_nseq = '0;
    logic [2:0]  cfg_cart_seqfast = '0;
    logic [5:0]  cyc_count;
    logic [5:0]  region_sel;
    logic        busy;
    logic        ready;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    memwait_timer u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .acc_strobe       (acc_strobe),
        .acc_addr         (acc_addr),
        .acc_word         (acc_word),
        .acc_seq          (acc_seq),
        .cfg_eram_wait    (cfg_eram_wait),
        .cfg_cart_nseq    (cfg_cart_nseq),
        .cfg_cart_seqfast (cfg_cart_seqfast),
        .cyc_count        (cyc_count),
        .region_sel       (region_sel),
        .busy             (busy),
        .ready            (ready)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic present(input vec_t v);
        acc_addr         = v.a;
        acc_word         = v.w;
        acc_seq          = v.s;
        cfg_eram_wait    = v.e;
        cfg_cart_nseq    = v.n;
        cfg_cart_seqfast = v.q;
    endtask

    // Start an access at the next edge; returns at the negedge after it.
    task automatic start(input vec_t v);
        @(negedge clk);
        present(v);
        acc_strobe = 1'b1;
        @(negedge clk);
        acc_strobe = 1'b0;
    endtask

    // Count the busy cycles up to and including ready (first already seen).
    task automatic wait_ready(output int k);
        k = 1;
        while (!ready && k < 64) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !ready, "R11 busy/ready after reset", {busy, ready}, 0);
        chk(cyc_count == 0 && region_sel == 0, "R11 count/region after reset",
            {cyc_count, region_sel}, 0);

        // Table walk for R1..R8 and R9 timing
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            start(v);
            chk(cyc_count == v.c, $sformatf("R%0d vec %0d count", v.rq, i), cyc_count, v.c);
            chk(region_sel == v.r, $sformatf("R8 vec %0d region", i), region_sel, v.r);
            chk(busy, $sformatf("R9 vec %0d busy", i), busy, 1);
            wait_ready(k);
            chk(k == v.c, $sformatf("R9 vec %0d ready cycle", i), k, v.c);
            @(negedge clk);
            chk(!busy, $sformatf("R9 vec %0d idle after ready", i), busy, 0);
        end

        // R10 configuration change during an access does not alter it
        v = '{32'h0200_0000, 1'b1, 1'b0, 4'd0, 8'hE4, 3'b010, 6'd32, ERM, 4'd10};
        start(v);
        cfg_eram_wait = 4'd15;
        cfg_cart_nseq = 8'h00;
        wait_ready(k);
        chk(k == 32, "R10 ready cycle after cfg change", k, 32);
        chk(cyc_count == 32, "R10 count held after cfg change", cyc_count, 32);
        @(negedge clk);

        // R10 strobe while busy and not ready is ignored
        v = '{32'h0200_0000, 1'b0, 1'b0, 4'd0, 8'hE4, 3'b010, 6'd16, ERM, 4'd10};
        start(v);
        @(negedge clk);
        @(negedge clk);
        acc_addr = 32'h0000_0000;
        acc_strobe = 1'b1;
        @(negedge clk);
        acc_strobe = 1'b0;
        chk(cyc_count == 16 && region_sel == ERM, "R10 mid-access strobe ignored",
            cyc_count, 16);
        k = 4;
        while (!ready && k < 64) begin
            @(negedge clk);
            k++;
        end
        chk(k == 16, "R10 ready cycle with ignored strobe", k, 16);
        @(negedge clk);
        chk(!busy, "R10 idle after ignored strobe", busy, 0);

        // R9 back-to-back strobe in the ready cycle
        v = '{32'h0300_0000, 1'b0, 1'b0, 4'd3, 8'hE4, 3'b010, 6'd1, FST, 4'd9};
        @(negedge clk);
        present(v);
        acc_strobe = 1'b1;
        @(negedge clk);
        chk(ready && cyc_count == 1, "R9 one-clock access ready", cyc_count, 1);
        acc_addr = 32'h0500_0000;
        acc_word = 1'b1;
        @(negedge clk);
        acc_strobe = 1'b0;
        chk(cyc_count == 2 && region_sel == VID, "R9 back-to-back accepted", cyc_count, 2);
        chk(busy && !ready, "R9 back-to-back first cycle", ready, 0);
        @(negedge clk);
        chk(ready, "R9 back-to-back ready on second cycle", ready, 1);
        @(negedge clk);
        chk(!busy, "R9 idle after back-to-back", busy, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule